// File: doc/BRIEF.md
# Single to Extended Float Widener

This block converts a 32-bit single-precision floating-point value into an 80-bit double-extended value whose significand carries its leading integer bit explicitly. The conversion is exact for every input: normal values are re-biased, tiny (denormal) inputs are normalised with a leading-zero count so that the integer bit of the result is set, and infinities and NaNs are mapped onto the all-ones exponent of the wide format.

Alongside the converted value the block reports a one-hot class of the input (zero, denormal, normal, infinity, quiet NaN, signalling NaN), an ordered indication that is true for every non-NaN input, an invalid-operation flag for a signalling NaN and a denormal-operand flag for a tiny input. NaNs leave the block quietened, so a signalling NaN can never come out of it.

The block is a single register stage. A value offered with `in_valid` high is captured on the rising clock edge, and its result is visible, with `out_valid` high, straight after that edge. The result holds while `in_valid` stays low.

Top module: `fpx_widen`

## Requirements
- R1: After a synchronous active-low reset every output is 0; a value presented with `in_valid` high on a rising edge appears on the outputs right after that edge with `out_valid` high, and `out_valid` is low after an edge where `in_valid` was low.
- R2: While `in_valid` is low, `out_bits`, `out_class` and all flags keep their last value whatever `in_bits` carries.
- R3: `out_bits` is laid out as sign in bit 79, a 15-bit exponent (bias 16383) in bits 78:64 and a 64-bit significand in bits 63:0 whose bit 63 is the explicit integer bit; the sign always equals input bit 31 (the input is sign in bit 31, 8-bit exponent with bias 127 in bits 30:23, fraction in bits 22:0).
- R4: For an input exponent of 1 to 254 the output exponent is the input exponent plus 16256, and the significand is a 1 followed by the 23 fraction bits and then 40 zeros (e.g. 0x3F800000 gives 0x3FFF8000000000000000).
- R5: An input with exponent 0 and zero fraction gives exponent 0 and significand 0 with the sign kept, class zero.
- R6: An input with exponent 0 and nonzero fraction (tiny) is normalised: with L the number of leading zeros of the 23-bit fraction, the exponent is 16256 - L and the significand is the fraction shifted left until its top set bit lands in bit 63; `flag_denormal` is set.
- R7: Exponent 255 with a zero fraction gives exponent 0x7FFF and significand 0x8000000000000000 with the input sign, class infinity.
- R8: Exponent 255 with a nonzero fraction is a NaN: quiet when fraction bit 22 is 1, signalling otherwise; the output exponent is 0x7FFF and the significand is bits 63 and 62 set, then fraction bits 21:0, then 40 zeros; `flag_invalid` is 1 only for the signalling kind.
- R9: `out_class` is one-hot with bit 0 zero, bit 1 denormal, bit 2 normal, bit 3 infinity, bit 4 quiet NaN, bit 5 signalling NaN; `out_ordered` is 1 exactly when the input is not a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture `in_bits` on this edge |
| in_bits | input | 32 | Single-precision input value |
| out_valid | output | 1 | A result was captured on the last edge |
| out_bits | output | 80 | Double-extended result |
| out_class | output | 6 | One-hot class of the input |
| out_ordered | output | 1 | Input is not a NaN |
| flag_invalid | output | 1 | Input was a signalling NaN |
| flag_denormal | output | 1 | Input was a tiny (denormal) value |

## Verification
The conversion is tried with ordinary normals (±1, 2, 3, a small fraction-heavy value) and with the smallest and largest normal exponents, which separate the re-bias from any off-by-one in the exponent. Tiny inputs with the top, bottom and a middle fraction bit as leading one tell a correct leading-zero count and shift apart from a fixed shift, and the pair largest-denormal / smallest-normal checks that the two paths meet without a gap. Signed zeros and infinities check that the sign survives the special paths, and quiet and signalling NaNs of both signs, including one whose only set fraction bit is bit 0, distinguish the quiet-bit test, the forced quiet bit and the invalid flag.

// File: rtl/fpx_pkg.sv
// Package fpx_pkg
// Shared format widths and the class bit positions of the widener.
// Assumes the narrow format is binary32 and the wide one has an explicit
// integer bit.
package fpx_pkg;
    localparam int IN_EXP   = 8;
    localparam int IN_FRAC  = 23;
    localparam int OUT_EXP  = 15;
    localparam int OUT_SIG  = 64;

    localparam int CLS_ZERO = 0;
    localparam int CLS_DEN  = 1;
    localparam int CLS_NORM = 2;
    localparam int CLS_INF  = 3;
    localparam int CLS_QNAN = 4;
    localparam int CLS_SNAN = 5;
    localparam int CLS_N    = 6;

    typedef logic [CLS_N-1:0] fpx_class_t;
endpackage

// File: rtl/fpx_lzc.sv
// Module fpx_lzc
// Counts leading zeros of a W-bit vector, scanning from the top bit.
// Assumes the caller ignores the count when the vector is all zeros
// (the count is then W).
module fpx_lzc #(
    parameter int W  = 23,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    logic [W:0] seen;

    // Running "a one has been seen above" chain, one stage per bit.
    assign seen[W] = 1'b0;
    for (genvar i = W - 1; i >= 0; i--) begin : g_scan
        assign seen[i] = seen[i+1] | vec[i];
    end

    // Count the positions above the first set bit.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            if (!seen[i]) count = count + 1'b1;
        end
    end
endmodule

// File: rtl/fpx_classify.sv
// Module fpx_classify
// Sorts an unpacked narrow float into one of six one-hot classes.
// Assumes exponent all ones means infinity or NaN and exponent zero
// means zero or tiny; the top fraction bit marks a quiet NaN.
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int EW = IN_EXP,
    parameter int FW = IN_FRAC
) (
    input  logic [EW-1:0] exp_f,
    input  logic [FW-1:0] frac_f,
    output fpx_class_t    cls
);
    logic exp_max, exp_min, frac_nz;

    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;
    assign frac_nz = |frac_f;

    // One-hot class decode from the exponent and fraction extremes.
    always_comb begin
        cls           = '0;
        cls[CLS_ZERO] = exp_min & ~frac_nz;
        cls[CLS_DEN]  = exp_min &  frac_nz;
        cls[CLS_NORM] = ~exp_min & ~exp_max;
        cls[CLS_INF]  = exp_max & ~frac_nz;
        cls[CLS_QNAN] = exp_max &  frac_f[FW-1];
        cls[CLS_SNAN] = exp_max & ~frac_f[FW-1] & frac_nz;
    end
endmodule

// File: rtl/fpx_assemble.sv
// Module fpx_assemble
// Builds the wide exponent and explicit-integer-bit significand from the
// narrow fields and their class. Pure combinational logic.
// Assumes cls is one-hot and lz is the leading-zero count of frac_f.
module fpx_assemble
    import fpx_pkg::*;
#(
    parameter int EW  = IN_EXP,
    parameter int FW  = IN_FRAC,
    parameter int XEW = OUT_EXP,
    parameter int XSW = OUT_SIG,
    localparam int CW       = $clog2(FW + 1),
    localparam int IN_BIAS  = (1 << (EW - 1)) - 1,
    localparam int OUT_BIAS = (1 << (XEW - 1)) - 1,
    localparam int PAD      = XSW - FW
) (
    input  logic [EW-1:0]   exp_f,
    input  logic [FW-1:0]   frac_f,
    input  logic [CW-1:0]   lz,
    input  fpx_class_t      cls,
    output logic [XEW-1:0]  x_exp,
    output logic [XSW-1:0]  x_sig
);
    localparam logic [XEW-1:0] BIAS_DIFF = XEW'(OUT_BIAS - IN_BIAS);

    logic [XEW-1:0] exp_norm, exp_den;
    logic [XSW-1:0] sig_norm, sig_den, sig_nan, sig_inf;

    // Candidate fields for each class, computed side by side.
    assign exp_norm = XEW'(exp_f) + BIAS_DIFF;
    assign exp_den  = BIAS_DIFF - XEW'(lz);
    assign sig_norm = {1'b1, frac_f, {(PAD-1){1'b0}}};
    assign sig_den  = {frac_f, {PAD{1'b0}}} << lz;
    assign sig_nan  = {2'b11, frac_f[FW-2:0], {(PAD-1){1'b0}}};
    assign sig_inf  = {1'b1, {(XSW-1){1'b0}}};

    // Select the fields of the active class.
    always_comb begin
        x_exp = '0;
        x_sig = '0;
        unique case (1'b1)
            cls[CLS_NORM]: begin x_exp = exp_norm; x_sig = sig_norm; end
            cls[CLS_DEN]:  begin x_exp = exp_den;  x_sig = sig_den;  end
            cls[CLS_INF]:  begin x_exp = '1;       x_sig = sig_inf;  end
            cls[CLS_QNAN],
            cls[CLS_SNAN]: begin x_exp = '1;       x_sig = sig_nan;  end
            default:       begin x_exp = '0;       x_sig = '0;       end
        endcase
    end
endmodule

// File: rtl/fpx_widen.sv
// Module fpx_widen (top)
// Single-stage converter from a narrow float with hidden integer bit to a
// wide float with explicit integer bit, with class and exception flags.
// Assumes in_bits is only meaningful when in_valid is high; outputs hold
// while in_valid is low. Synchronous active-low reset clears everything.
module fpx_widen
    import fpx_pkg::*;
#(
    parameter int EW  = IN_EXP,
    parameter int FW  = IN_FRAC,
    parameter int XEW = OUT_EXP,
    parameter int XSW = OUT_SIG,
    localparam int IW = 1 + EW + FW,
    localparam int OW = 1 + XEW + XSW,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_bits,
    output logic          out_valid,
    output logic [OW-1:0] out_bits,
    output logic [CLS_N-1:0] out_class,
    output logic          out_ordered,
    output logic          flag_invalid,
    output logic          flag_denormal
);
    logic           in_sign;
    logic [EW-1:0]  in_exp;
    logic [FW-1:0]  in_frac;
    logic [CW-1:0]  lz;
    fpx_class_t     cls;
    logic [XEW-1:0] x_exp;
    logic [XSW-1:0] x_sig;
    logic           is_nan;

    assign in_sign = in_bits[IW-1];
    assign in_exp  = in_bits[IW-2:FW];
    assign in_frac = in_bits[FW-1:0];

    // NaN test kept apart from the class decode for the ordered output.
    assign is_nan = (&in_exp) & (|in_frac);

    fpx_lzc #(.W(FW)) u_lzc (
        .vec   (in_frac),
        .count (lz)
    );

    fpx_classify #(.EW(EW), .FW(FW)) u_cls (
        .exp_f  (in_exp),
        .frac_f (in_frac),
        .cls    (cls)
    );

    fpx_assemble #(.EW(EW), .FW(FW), .XEW(XEW), .XSW(XSW)) u_asm (
        .exp_f  (in_exp),
        .frac_f (in_frac),
        .lz     (lz),
        .cls    (cls),
        .x_exp  (x_exp),
        .x_sig  (x_sig)
    );

    // Output register: clear on reset, load on in_valid, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_bits      <= '0;
            out_class     <= '0;
            out_ordered   <= 1'b0;
            flag_invalid  <= 1'b0;
            flag_denormal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bits      <= {in_sign, x_exp, x_sig};
                out_class     <= cls;
                out_ordered   <= ~is_nan;
                flag_invalid  <= cls[CLS_SNAN];
                flag_denormal <= cls[CLS_DEN];
            end
        end
    end
endmodule

// File: rtl/fpx_widen_chk.sv
// Module fpx_widen_chk
// Property checker bound to every fpx_widen instance. Observes ports only.
// Assumes the default formats (80-bit result with 15-bit exponent).
module fpx_widen_chk
    import fpx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_bits,
    input logic        out_valid,
    input logic [79:0] out_bits,
    input logic [5:0]  out_class,
    input logic        out_ordered,
    input logic        flag_invalid,
    input logic        flag_denormal
);
    logic        nan_out;
    logic        spc_out;
    logic [14:0] o_exp;

    assign o_exp   = out_bits[78:64];
    assign nan_out = out_class[CLS_QNAN] | out_class[CLS_SNAN];
    assign spc_out = nan_out | out_class[CLS_INF];

    p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bits) && $stable(out_class));
    p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_bits[79] == $past(in_bits[31]));
    p_int_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_class[CLS_ZERO]) |-> out_bits[63]);
    p_tiny_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_denormal) |-> (o_exp < 15'h3F81));
    p_special_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && spc_out) |-> (o_exp == 15'h7FFF));
    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nan_out) |-> (out_bits[63:62] == 2'b11));
    p_invalid_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> (o_exp == 15'h7FFF && out_class[CLS_SNAN]));
    p_class_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_class) == 1));
    p_ordered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ordered == !nan_out));
endmodule

bind fpx_widen fpx_widen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_bits       (in_bits),
    .out_valid     (out_valid),
    .out_bits      (out_bits),
    .out_class     (out_class),
    .out_ordered   (out_ordered),
    .flag_invalid  (flag_invalid),
    .flag_denormal (flag_denormal)
);

// File: tb/sim_fpx_widen.sv
// Bench for fpx_widen: a vector table walked by one loop, then directed
// tests for reset and holding.
module sim_fpx_widen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        out_valid;
    logic [79:0] out_bits;
    logic [5:0]  out_class;
    logic        out_ordered;
    logic        flag_invalid;
    logic        flag_denormal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpx_widen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_bits       (in_bits),
        .out_valid     (out_valid),
        .out_bits      (out_bits),
        .out_class     (out_class),
        .out_ordered   (out_ordered),
        .flag_invalid  (flag_invalid),
        .flag_denormal (flag_denormal)
    );

    // Class one-hot codes (R9).
    localparam logic [5:0] CZ = 6'b000001, CD = 6'b000010, CN = 6'b000100,
                           CI = 6'b001000, CQ = 6'b010000, CS = 6'b100000;

    // {input, result, class, invalid, denormal}
    localparam int NV = 19;
    localparam logic [119:0] VEC [NV] = '{
        {32'h3F800000, 80'h3FFF8000000000000000, CN, 1'b0, 1'b0},
        {32'hBF800000, 80'hBFFF8000000000000000, CN, 1'b0, 1'b0},
        {32'h40000000, 80'h40008000000000000000, CN, 1'b0, 1'b0},
        {32'h40400000, 80'h4000C000000000000000, CN, 1'b0, 1'b0},
        {32'h33D6BF95, 80'h3FE7D6BF950000000000, CN, 1'b0, 1'b0},
        {32'h7F7FFFFF, 80'h407EFFFFFF0000000000, CN, 1'b0, 1'b0},
        {32'h00800000, 80'h3F818000000000000000, CN, 1'b0, 1'b0},
        {32'h00000000, 80'h00000000000000000000, CZ, 1'b0, 1'b0},
        {32'h80000000, 80'h80000000000000000000, CZ, 1'b0, 1'b0},
        {32'h00000001, 80'h3F6A8000000000000000, CD, 1'b0, 1'b1},
        {32'h007FFFFF, 80'h3F80FFFFFE0000000000, CD, 1'b0, 1'b1},
        {32'h80400000, 80'hBF808000000000000000, CD, 1'b0, 1'b1},
        {32'h00000300, 80'h3F73C000000000000000, CD, 1'b0, 1'b1},
        {32'h7F800000, 80'h7FFF8000000000000000, CI, 1'b0, 1'b0},
        {32'hFF800000, 80'hFFFF8000000000000000, CI, 1'b0, 1'b0},
        {32'h7FC00000, 80'h7FFFC000000000000000, CQ, 1'b0, 1'b0},
        {32'h7F800001, 80'h7FFFC000010000000000, CS, 1'b1, 1'b0},
        {32'hFFBFFFFF, 80'hFFFFFFFFFF0000000000, CS, 1'b1, 1'b0},
        {32'hFFFFFFFF, 80'hFFFFFFFFFF0000000000, CQ, 1'b0, 1'b0}
    };
    // Requirement each vector mainly exercises.
    string VTAG [NV] = '{"R4", "R3", "R4", "R4", "R4", "R4", "R4",
                         "R5", "R5", "R6", "R6", "R6", "R6",
                         "R7", "R7", "R8", "R8", "R8", "R8"};

    task automatic check(input string tag, input logic [79:0] act,
                         input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [79:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, all outputs cleared.
        check("R1 reset out_valid", 80'(out_valid), 80'd0);
        check("R1 reset out_bits", out_bits, 80'd0);
        check("R1 reset class/flags",
              80'({out_class, out_ordered, flag_invalid, flag_denormal}), 80'd0);

        @(negedge clk) rst_n = 1'b1;

        // Table walk: one new input per cycle, checked after its capture edge.
        for (int i = 0; i < NV; i++) begin
            logic [119:0] v;
            v = VEC[i];
            @(negedge clk);
            in_valid = 1'b1;
            in_bits  = v[119:88];
            @(posedge clk);
            #1;
            check({VTAG[i], " R1 valid"}, 80'(out_valid), 80'd1);
            check({VTAG[i], " R3 bits"}, out_bits, v[87:8]);
            check({VTAG[i], " R9 class"}, 80'(out_class), 80'(v[7:2]));
            check({VTAG[i], " R9 ordered"}, 80'(out_ordered),
                  80'(!(v[7] | v[6])));
            check({VTAG[i], " R8 invalid"}, 80'(flag_invalid), 80'(v[1]));
            check({VTAG[i], " R6 denormal"}, 80'(flag_denormal), 80'(v[0]));
        end

        // R2: in_valid low, new input bits must not reach the outputs.
        held = out_bits;
        @(negedge clk);
        in_valid = 1'b0;
        in_bits  = 32'h00000001;
        repeat (2) @(posedge clk);
        #1;
        check("R1 idle out_valid", 80'(out_valid), 80'd0);
        check("R2 hold out_bits", out_bits, held);
        check("R2 hold class", 80'(out_class), 80'(CQ));
        check("R2 hold denormal flag", 80'(flag_denormal), 80'd0);

        // R1: a single valid beat after idle, then reset mid-run clears.
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = 32'hC0400000;
        @(posedge clk);
        #1;
        check("R4 single beat -3.0", out_bits, 80'hC000C000000000000000);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset again out_bits", out_bits, 80'd0);
        check("R1 reset again class", 80'(out_class), 80'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset idle", 80'(out_valid), 80'd0);

        done = 1'b1;
        finish_run();
    end
endmodule